// File: doc/BRIEF.md
# Multirate Narrowband Lowpass Chain

This block is a narrowband lowpass filter built from three cascaded FIR stages. The filter leaves the full sample rate only inside itself. A 17-tap decimating stage keeps one result out of every four input samples. A 38-tap narrowband stage then runs on that quarter-rate stream. A 9-tap interpolating stage brings the stream back to the full rate, which is equivalent to inserting three zeros between low-rate samples and then smoothing. The three stages need 64 coefficients in total. A single-rate filter with the same narrow passband would need about 150.

Samples enter as signed fixed-point words with a valid strobe at the full rate. For every accepted input, one filtered sample leaves one clock later. Cycles where the strobe is low have no effect, so the upstream source may pause at any time. The coefficient sets are elaboration-time parameters. Each coefficient is a signed word with `FRAC` fractional bits. The rate factor is an integer parameter with a default of 4. Each stage accumulates at full precision, then rounds and saturates back to the sample width.

Top module: `nbf_chain`

## Requirements
- R1: A synchronous active-high reset clears the slot counter, every delay line and every stage result. In the cycle after reset, `out_valid` is 0 and `out_data` is 0. The outputs that follow are identical to those after the first reset.
- R2: For each cycle with `in_valid` high, `out_valid` is high in the next cycle. `out_valid` is never high at any other time, so the count of outputs equals the count of inputs.
- R3: Number the valid input slots from 0 since reset; samples before slot 0 count as 0. The decimating stage forms d[m] = RS(sum over k of hd[k]·x[4m+3−k]) for k = 0..16. It takes this result only on slots 3, 7, 11, and so on (every fourth valid input).
- R4: The narrowband stage forms nb[j] = RS(sum over k of hn[k]·d[j−1−k]) for k = 0..37, on slot 4j. Here d values with a negative index are 0.
- R5: The interpolating stage outputs y[0] = 0. For n ≥ 1 it outputs y[n] = RS(sum over k of hi[q+4k]·nb[j−k]), with j = floor((n−1)/4) and q = (n−1) mod 4. Products whose tap index q+4k exceeds 8 are omitted, because they fall on stuffed zeros.
- R6: RS rounds a stage sum by adding 2^(FRAC−1) and then shifting arithmetically right by FRAC bits, so exact halves round toward positive infinity.
- R7: After rounding, each stage clamps its result to the range from −2^(DW−1) to 2^(DW−1)−1.
- R8: While `in_valid` is low, `in_data` is ignored and `out_data` holds its value. The output values depend only on the sequence of valid samples, not on the gaps between them.
- R9: A sample at slot n first affects the output produced for slot 4·floor(n/4)+5. For example, a sample at slot 0 or slot 4 first shows at output slot 5 or slot 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe at the full rate |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample strobe, one cycle after each input strobe |
| out_data | output | DW | Signed filtered output sample |

## Verification
The slot counter feeds all three stages at once. A slip in it therefore moves the quarter-rate samples to the wrong output slots, and an impulse shows this within one decimation period as a first nonzero output away from slot 5. A delay line that is not cleared, or one that shifts on an idle cycle, corrupts the very next impulse or gapped run long before the 38-tap stage settles. Rounding and clamping faults appear as an offset of one LSB, or as wrap-around, in the steady output for a constant input. This is most visible on a second instance whose reduced FRAC drives every stage into its limits.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  // Round half up by FRAC bits, then clamp to a signed OW-bit range.
  function automatic longint round_sat(input longint acc, input int frac, input int ow);
    longint r;
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -(longint'(1) <<< (ow - 1));
    if (frac > 0) r = (acc + (longint'(1) <<< (frac - 1))) >>> frac;
    else          r = acc;
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/nbf_fir_stage.sv
// Transversal FIR stage: the delay line shifts on shift_en, and the
// rounded sum (including the incoming sample) is registered on load_en.
module nbf_fir_stage #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  parameter int TAPS = 17,
  parameter logic signed [CW-1:0] COEF [TAPS] = '{default: '0}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 load_en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);
  localparam int AW = DW + CW + $clog2(TAPS) + 1;

  logic signed [DW-1:0] line_q [TAPS];
  logic signed [DW-1:0] line_d [TAPS];
  logic signed [AW-1:0] acc;

  always_comb begin
    line_d[0] = din;
    for (int k = 1; k < TAPS; k++) line_d[k] = line_q[k-1];
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + AW'(COEF[k]) * AW'(line_d[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '{default: '0};
      dout   <= '0;
    end else begin
      if (shift_en) line_q <= line_d;
      if (load_en)  dout   <= DW'(nbf_pkg::round_sat(64'(acc), FRAC, DW));
    end
  end
endmodule

// File: rtl/nbf_interp.sv
// Polyphase interpolator: only the taps that meet real low-rate samples
// are multiplied; the sub-phase selects which tap subset is used.
module nbf_interp #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  parameter int RATE = 4,
  parameter int TAPS = 9,
  parameter logic signed [CW-1:0] COEF [TAPS] = '{default: '0}
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_en,
  input  logic                          step_en,
  input  logic [$clog2(RATE)-1:0]       sub,
  input  logic signed [DW-1:0]          din,
  output logic signed [DW-1:0]          dout
);
  localparam int LEN = (TAPS + RATE - 1) / RATE;
  localparam int AW  = DW + CW + $clog2(LEN) + 1;

  logic signed [CW-1:0] pc     [RATE][LEN];
  logic signed [DW-1:0] line_q [LEN];
  logic signed [DW-1:0] line_d [LEN];
  logic signed [DW-1:0] cur    [LEN];
  logic signed [AW-1:0] acc;

  for (genvar r = 0; r < RATE; r++) begin : g_phase
    for (genvar k = 0; k < LEN; k++) begin : g_tap
      if (r + RATE * k < TAPS) begin : g_live
        assign pc[r][k] = COEF[r + RATE * k];
      end else begin : g_pad
        assign pc[r][k] = '0;
      end
    end
  end

  always_comb begin
    line_d[0] = din;
    for (int k = 1; k < LEN; k++) line_d[k] = line_q[k-1];
    for (int k = 0; k < LEN; k++) cur[k] = load_en ? line_d[k] : line_q[k];
    acc = '0;
    for (int k = 0; k < LEN; k++) acc = acc + AW'(pc[sub][k]) * AW'(cur[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '{default: '0};
      dout   <= '0;
    end else begin
      if (load_en) line_q <= line_d;
      if (step_en) dout   <= DW'(nbf_pkg::round_sat(64'(acc), FRAC, DW));
    end
  end
endmodule

// File: rtl/nbf_chain.sv
module nbf_chain #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int FRAC     = 15,
  parameter int RATE     = 4,
  parameter int DEC_TAPS = 17,
  parameter int NB_TAPS  = 38,
  parameter int INT_TAPS = 9,
  parameter logic signed [CW-1:0] DEC_COEF [DEC_TAPS] = '{
    16'sd404,  16'sd808,  16'sd1212, 16'sd1616, 16'sd2020, 16'sd2424,
    16'sd2828, 16'sd3232, 16'sd3636, 16'sd3232, 16'sd2828, 16'sd2424,
    16'sd2020, 16'sd1616, 16'sd1212, 16'sd808,  16'sd404},
  parameter logic signed [CW-1:0] NB_COEF [NB_TAPS] = '{
    16'sd86,   16'sd172,  16'sd258,  16'sd344,  16'sd430,  16'sd516,
    16'sd602,  16'sd688,  16'sd774,  16'sd860,  16'sd946,  16'sd1032,
    16'sd1118, 16'sd1204, 16'sd1290, 16'sd1376, 16'sd1462, 16'sd1548,
    16'sd1634, 16'sd1634, 16'sd1548, 16'sd1462, 16'sd1376, 16'sd1290,
    16'sd1204, 16'sd1118, 16'sd1032, 16'sd946,  16'sd860,  16'sd774,
    16'sd688,  16'sd602,  16'sd516,  16'sd430,  16'sd344,  16'sd258,
    16'sd172,  16'sd86},
  parameter logic signed [CW-1:0] INT_COEF [INT_TAPS] = '{
    16'sd4096,  16'sd8192,  16'sd16384, 16'sd24576, 16'sd24576,
    16'sd24576, 16'sd16384, 16'sd8192,  16'sd4096}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int PW = $clog2(RATE);

  logic [PW-1:0]        phase_q;
  logic [PW-1:0]        sub;
  logic                 dec_load;
  logic                 nb_step;
  logic                 int_load;
  logic signed [DW-1:0] dec_out;
  logic signed [DW-1:0] nb_out;

  // Slot schedule: decimate on the last slot of a group, run the
  // narrowband stage on the next slot 0, feed the interpolator on slot 1.
  assign dec_load = in_valid && (phase_q == PW'(RATE - 1));
  assign nb_step  = in_valid && (phase_q == '0);
  assign int_load = in_valid && (phase_q == PW'(1));
  assign sub      = (phase_q == '0) ? PW'(RATE - 1) : phase_q - PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) phase_q <= (phase_q == PW'(RATE - 1)) ? '0 : phase_q + PW'(1);
    end
  end

  nbf_fir_stage #(
    .DW(DW), .CW(CW), .FRAC(FRAC), .TAPS(DEC_TAPS), .COEF(DEC_COEF)
  ) dec_i (
    .clk(clk), .rst(rst), .shift_en(in_valid), .load_en(dec_load),
    .din(in_data), .dout(dec_out)
  );

  nbf_fir_stage #(
    .DW(DW), .CW(CW), .FRAC(FRAC), .TAPS(NB_TAPS), .COEF(NB_COEF)
  ) nb_i (
    .clk(clk), .rst(rst), .shift_en(nb_step), .load_en(nb_step),
    .din(dec_out), .dout(nb_out)
  );

  nbf_interp #(
    .DW(DW), .CW(CW), .FRAC(FRAC), .RATE(RATE), .TAPS(INT_TAPS), .COEF(INT_COEF)
  ) int_i (
    .clk(clk), .rst(rst), .load_en(int_load), .step_en(in_valid),
    .sub(sub), .din(nb_out), .dout(out_data)
  );
endmodule

// File: rtl/nbf_chain_chk.sv
module nbf_chain_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data
);
  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  out_origin_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));
endmodule

bind nbf_chain nbf_chain_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/nbf_chain_tb_top.sv
`timescale 1ns/1ps
module nbf_chain_tb_top;
  localparam int DW     = 16;
  localparam int CW     = 16;
  localparam int FRAC   = 15;
  localparam int FRAC_S = 13;
  localparam int NMAX   = 64;

  localparam logic signed [CW-1:0] HD [17] = '{
    16'sd404,  16'sd808,  16'sd1212, 16'sd1616, 16'sd2020, 16'sd2424,
    16'sd2828, 16'sd3232, 16'sd3636, 16'sd3232, 16'sd2828, 16'sd2424,
    16'sd2020, 16'sd1616, 16'sd1212, 16'sd808,  16'sd404};
  localparam logic signed [CW-1:0] HN [38] = '{
    16'sd86,   16'sd172,  16'sd258,  16'sd344,  16'sd430,  16'sd516,
    16'sd602,  16'sd688,  16'sd774,  16'sd860,  16'sd946,  16'sd1032,
    16'sd1118, 16'sd1204, 16'sd1290, 16'sd1376, 16'sd1462, 16'sd1548,
    16'sd1634, 16'sd1634, 16'sd1548, 16'sd1462, 16'sd1376, 16'sd1290,
    16'sd1204, 16'sd1118, 16'sd1032, 16'sd946,  16'sd860,  16'sd774,
    16'sd688,  16'sd602,  16'sd516,  16'sd430,  16'sd344,  16'sd258,
    16'sd172,  16'sd86};
  localparam logic signed [CW-1:0] HI [9] = '{
    16'sd4096,  16'sd8192,  16'sd16384, 16'sd24576, 16'sd24576,
    16'sd24576, 16'sd16384, 16'sd8192,  16'sd4096};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid_a, out_valid_b;
  logic signed [DW-1:0] out_data_a, out_data_b;

  always #4 clk = ~clk;

  nbf_chain #(.DW(DW), .CW(CW), .FRAC(FRAC),
              .DEC_COEF(HD), .NB_COEF(HN), .INT_COEF(HI)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_a), .out_data(out_data_a));

  nbf_chain #(.DW(DW), .CW(CW), .FRAC(FRAC_S),
              .DEC_COEF(HD), .NB_COEF(HN), .INT_COEF(HI)) dut_sat_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_b), .out_data(out_data_b));

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  longint xs [NMAX];
  int nx;
  int first_nz;
  longint last_a, last_b;

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint rsat(input longint a, input int frac);
    longint r;
    r = (a + (longint'(1) <<< (frac - 1))) >>> frac;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // Golden response from the R3/R4/R5 equations.
  task automatic build_model(input int frac, output longint y [NMAX]);
    longint d [NMAX];
    longint nb [NMAX];
    for (int m = 0; m < NMAX; m++) begin
      longint acc = 0;
      for (int k = 0; k < 17; k++) begin
        int idx = 4 * m + 3 - k;
        if (idx >= 0 && idx < nx) acc += longint'(HD[k]) * xs[idx];
      end
      d[m] = rsat(acc, frac);
    end
    for (int j = 0; j < NMAX; j++) begin
      longint acc = 0;
      for (int k = 0; k < 38; k++) begin
        int idx = j - 1 - k;
        if (idx >= 0) acc += longint'(HN[k]) * d[idx];
      end
      nb[j] = rsat(acc, frac);
    end
    for (int n = 0; n < NMAX; n++) begin
      if (n == 0) y[n] = 0;
      else begin
        longint acc = 0;
        int j = (n - 1) / 4;
        int q = (n - 1) % 4;
        for (int k = 0; k < 3; k++) begin
          if (q + 4 * k < 9 && j - k >= 0) acc += longint'(HI[q + 4 * k]) * nb[j - k];
        end
        y[n] = rsat(acc, frac);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset out_valid", out_valid_a, 0);
    check("R1 reset out_data", out_data_a, 0);
    check("R1 reset out_valid sat", out_valid_b, 0);
    check("R1 reset out_data sat", out_data_b, 0);
    rst = 1'b0;
  endtask

  task automatic run(input string req, input bit gaps);
    longint ea [NMAX];
    longint eb [NMAX];
    int ia = 0, oa = 0, ob = 0, cyc = 0;
    build_model(FRAC, ea);
    build_model(FRAC_S, eb);
    first_nz = -1;
    while ((oa < nx || ob < nx) && cyc < 1000) begin
      @(negedge clk);
      if (out_valid_a) begin
        if (oa < nx) begin
          check(req, out_data_a, ea[oa]);
          if (first_nz < 0 && out_data_a != 0) first_nz = oa;
          last_a = out_data_a;
        end else check({req, " R2 extra output"}, 1, 0);
        oa++;
      end
      if (out_valid_b) begin
        if (ob < nx) begin
          check({req, " sat"}, out_data_b, eb[ob]);
          last_b = out_data_b;
        end else check({req, " R2 extra output sat"}, 1, 0);
        ob++;
      end
      if (ia < nx && !(gaps && (cyc % 3 == 1))) begin
        in_valid = 1'b1;
        in_data  = DW'(xs[ia]);
        ia++;
      end else begin
        in_valid = 1'b0;
        in_data  = 16'sh5A5A;
      end
      cyc++;
    end
    @(negedge clk);
    check("R2 no output without input", out_valid_a, 0);
    check("R2 output count", oa, nx);
  endtask

  task automatic t_impulse();
    do_reset();
    nx = 40;
    for (int i = 0; i < nx; i++) xs[i] = 0;
    xs[0] = 32767;
    run("R3/R5 impulse", 1'b0);
    check("R9 first affected output slot", first_nz, 5);
  endtask

  task automatic t_phase();
    do_reset();
    nx = 40;
    for (int i = 0; i < nx; i++) xs[i] = 0;
    xs[4] = 32767;
    run("R3 decimation phase", 1'b0);
    check("R3 impulse at slot 4 lands in second group", first_nz, 9);
  endtask

  task automatic t_dc();
    do_reset();
    nx = 48;
    for (int i = 0; i < nx; i++) xs[i] = 12000;
    run("R4/R6 constant input", 1'b0);
  endtask

  task automatic t_gaps();
    do_reset();
    nx = 48;
    for (int i = 0; i < nx; i++) xs[i] = ((i * 7919) % 20001) - 10000;
    run("R8 gapped stream", 1'b1);
  endtask

  task automatic t_sat();
    do_reset();
    nx = 48;
    for (int i = 0; i < nx; i++) xs[i] = 20000;
    run("R7 positive", 1'b0);
    check("R7 positive clamp", last_b, 32767);
    do_reset();
    for (int i = 0; i < nx; i++) xs[i] = -20000;
    run("R7 negative", 1'b0);
    check("R7 negative clamp", last_b, -32768);
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'sd30000;
    end
    @(negedge clk);
    in_valid = 1'b0;
    do_reset();
    nx = 40;
    for (int i = 0; i < nx; i++) xs[i] = 0;
    xs[1] = -25000;
    run("R1 state cleared after mid-stream reset", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_impulse();
    t_phase();
    t_dc();
    t_gaps();
    t_sat();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule